// File: doc/BRIEF.md
# Host-Driven Program Bootstrap Loader

This block fills program memory from the host byte port while the processor core is held in bootstrap mode. Entering bootstrap clears the load pointer to word zero. Each program word arrives as two host writes: the high byte goes to a staging register, and the low byte then commits the whole word to program RAM at the pointer. The pointer then steps forward by one.

Bootstrap ends in one of two ways. It ends when the last word of the fixed-size image has been committed. It also ends at once when the host writes its control register with the early-exit flag set. Either exit releases the core with a single-cycle start pulse and a start address of zero. While loading, the two byte offsets are taken by the loader and never reach the normal host register path. All other host writes are forwarded to that path, and so is every write made after bootstrap has ended. The core fetches from the same RAM through a synchronous read port.

Top module: `hbl_loader`

## Requirements
- R1: After reset, `boot_active`, `core_start` and `pass_wr` are all 0.
- R2: A one-cycle `boot_enter` pulse sets `boot_active` on the next edge and puts the load pointer at word 0. A later entry starts again from word 0.
- R3: While bootstrap is active, a write to host offset 6 loads the staging byte. A write to host offset 7 stores {staging byte, written byte} into program RAM at the pointer, with the staging byte in bits 15:8, and then advances the pointer by one.
- R4: The staging byte is cleared to 0 on entry and keeps its last value until offset 6 is written again. A low-byte write without a fresh high byte therefore reuses it.
- R5: `boot_active` stays 1 through the first WORD_COUNT-1 committed words. It falls on the same edge that commits word WORD_COUNT-1.
- R6: While bootstrap is active, a write to host offset 0 with data bit 3 set ends bootstrap on that edge. It commits no word and is not forwarded.
- R7: On either exit, `core_start` is 1 for exactly one cycle, the cycle right after the exit edge, and `core_start_addr` is 0.
- R8: While bootstrap is active, writes to offsets 6 and 7 never appear on the pass port. Writes to offsets 1 to 5, and writes to offset 0 with bit 3 clear, appear on `pass_wr`/`pass_addr`/`pass_data` one cycle later.
- R9: Once bootstrap has ended, every host write, offsets 6 and 7 included, is forwarded one cycle later, and program RAM is left unchanged.
- R10: `pm_rd_data` returns the word stored at `pm_rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_enter | input | 1 | Pulse that enters bootstrap mode |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 3 | Host register offset |
| host_data | input | BYTE_W | Host write data |
| pm_rd_addr | input | AW | Core fetch address into program RAM |
| pm_rd_data | output | WORD_W | Program word, one cycle after the address |
| boot_active | output | 1 | High while bootstrap loading is in progress |
| core_start | output | 1 | One-cycle release pulse on bootstrap exit |
| core_start_addr | output | AW | Address at which the core starts (zero) |
| pass_wr | output | 1 | Forwarded write strobe to the normal host registers |
| pass_addr | output | 3 | Forwarded offset |
| pass_data | output | BYTE_W | Forwarded data |

## Verification
Loading is driven with random mixes of high-byte writes, low-byte writes, forwarded offsets and control writes with bit 3 clear. Repeated or missing high bytes then show whether the staging byte is truly held and not rebuilt for each word. A directed low byte sent right after entry shows the staging byte is cleared, and a full-size load with no interruptions shows the exit falls exactly on the last word and not one word early or late. Byte writes sent after an early exit, with the RAM read back afterwards, tell forwarding apart from silent writes into memory. A second entry shows the pointer returns to word zero.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  localparam int HOST_AW = 3;
  localparam logic [HOST_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [HOST_AW-1:0] OFS_HI   = 3'd6;
  localparam logic [HOST_AW-1:0] OFS_LO   = 3'd7;
  localparam int EXIT_BIT = 3;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_HI   = 2'd1,
    ACT_LO   = 2'd2,
    ACT_EXIT = 2'd3
  } host_act_e;
endpackage

// File: rtl/hbl_decode.sv
module hbl_decode
  import hbl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 active,
  input  logic [HOST_AW-1:0]   addr,
  input  logic [BYTE_W-1:0]    data,
  output host_act_e            act
);
  always_comb begin
    act = ACT_PASS;
    if (active) begin
      if (addr == OFS_HI)
        act = ACT_HI;
      else if (addr == OFS_LO)
        act = ACT_LO;
      else if (addr == OFS_CTRL && data[EXIT_BIT])
        act = ACT_EXIT;
    end
  end
endmodule

// File: rtl/hbl_seq.sv
module hbl_seq #(
  parameter int WORD_COUNT = 2048,
  parameter int CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic             lo_commit,
  input  logic             exit_req,
  output logic             active,
  output logic [CNT_W-1:0] ptr,
  output logic             start
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_COUNT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ptr    <= '0;
      start  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (enter) begin
        active <= 1'b1;
        ptr    <= '0;
      end else if (active) begin
        if (exit_req) begin
          active <= 1'b0;
          start  <= 1'b1;
        end else if (lo_commit) begin
          ptr <= ptr + 1'b1;
          if (ptr == LAST) begin
            active <= 1'b0;
            start  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hbl_pram.sv
module hbl_pram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 16,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hbl_loader.sv
module hbl_loader
  import hbl_pkg::*;
#(
  parameter  int WORD_COUNT = 2048,
  parameter  int BYTE_W     = 8,
  localparam int WORD_W     = 2 * BYTE_W,
  localparam int AW         = $clog2(WORD_COUNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boot_enter,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [BYTE_W-1:0]  host_data,
  input  logic [AW-1:0]      pm_rd_addr,
  output logic [WORD_W-1:0]  pm_rd_data,
  output logic               boot_active,
  output logic               core_start,
  output logic [AW-1:0]      core_start_addr,
  output logic               pass_wr,
  output logic [HOST_AW-1:0] pass_addr,
  output logic [BYTE_W-1:0]  pass_data
);
  localparam int CNT_W = AW + 1;

  host_act_e        act;
  logic [CNT_W-1:0] ptr;
  logic [BYTE_W-1:0] stage_q;
  logic             ram_we;
  logic             wr_ok;

  assign wr_ok  = host_wr && !boot_enter;
  assign ram_we = wr_ok && (act == ACT_LO);

  hbl_decode #(.BYTE_W(BYTE_W)) u_dec (
    .active (boot_active),
    .addr   (host_addr),
    .data   (host_data),
    .act    (act)
  );

  hbl_seq #(.WORD_COUNT(WORD_COUNT), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enter     (boot_enter),
    .lo_commit (ram_we),
    .exit_req  (wr_ok && (act == ACT_EXIT)),
    .active    (boot_active),
    .ptr       (ptr),
    .start     (core_start)
  );

  hbl_pram #(.DEPTH(WORD_COUNT), .DW(WORD_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ptr[AW-1:0]),
    .wdata ({stage_q, host_data}),
    .raddr (pm_rd_addr),
    .rdata (pm_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || boot_enter)
      stage_q <= '0;
    else if (wr_ok && act == ACT_HI)
      stage_q <= host_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_wr   <= 1'b0;
      pass_addr <= '0;
      pass_data <= '0;
    end else begin
      pass_wr <= wr_ok && (act == ACT_PASS);
      if (wr_ok && act == ACT_PASS) begin
        pass_addr <= host_addr;
        pass_data <= host_data;
      end
    end
  end

  assign core_start_addr = '0;
endmodule

// File: rtl/hbl_loader_chk.sv
module hbl_loader_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_enter,
  input logic              host_wr,
  input logic [2:0]        host_addr,
  input logic [BYTE_W-1:0] host_data,
  input logic              boot_active,
  input logic              core_start,
  input logic              pass_wr,
  input logic [2:0]        pass_addr,
  input logic [BYTE_W-1:0] pass_data,
  input logic              ram_we
);
  a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  a_r7_start_on_exit: assert property (@(posedge clk) disable iff (rst)
    core_start |-> (!boot_active && $past(boot_active)));

  a_r2_enter_sets_active: assert property (@(posedge clk) disable iff (rst)
    boot_enter |=> boot_active);

  a_r8_bytes_held: assert property (@(posedge clk) disable iff (rst)
    (boot_active && host_wr && !boot_enter && host_addr[2:1] == 2'b11) |=> !pass_wr);

  a_r6_early_exit: assert property (@(posedge clk) disable iff (rst)
    (boot_active && host_wr && !boot_enter && host_addr == 3'd0 && host_data[3])
      |=> (!boot_active && core_start && !pass_wr));

  a_r9_pass_after_exit: assert property (@(posedge clk) disable iff (rst)
    (!boot_active && host_wr && !boot_enter)
      |=> (pass_wr && pass_addr == $past(host_addr) && pass_data == $past(host_data)));

  a_r9_ram_quiet: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> boot_active);
endmodule

bind hbl_loader hbl_loader_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .boot_enter  (boot_enter),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .host_data   (host_data),
  .boot_active (boot_active),
  .core_start  (core_start),
  .pass_wr     (pass_wr),
  .pass_addr   (pass_addr),
  .pass_data   (pass_data),
  .ram_we      (ram_we)
);

// File: tb/tb_hbl_loader.sv
module tb_hbl_loader;
  localparam int WORDS = 2048;
  localparam int AW    = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_enter = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_data = '0;
  logic [AW-1:0] pm_rd_addr = '0;
  logic [15:0] pm_rd_data;
  logic        boot_active, core_start, pass_wr;
  logic [AW-1:0] core_start_addr;
  logic [2:0]  pass_addr;
  logic [7:0]  pass_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mdl_mem [WORDS];
  int          mdl_ptr = 0;
  logic [7:0]  mdl_stage = '0;
  bit          mdl_act = 0;

  always #4 clk = ~clk;

  hbl_loader dut (
    .clk(clk), .rst(rst), .boot_enter(boot_enter), .host_wr(host_wr),
    .host_addr(host_addr), .host_data(host_data), .pm_rd_addr(pm_rd_addr),
    .pm_rd_data(pm_rd_data), .boot_active(boot_active), .core_start(core_start),
    .core_start_addr(core_start_addr), .pass_wr(pass_wr), .pass_addr(pass_addr),
    .pass_data(pass_data)
  );

  function automatic logic [15:0] exp_word(logic [7:0] hi, logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic bit exp_pass(bit act, logic [2:0] a, logic [7:0] d);
    if (!act) return 1'b1;
    if (a == 3'd6 || a == 3'd7) return 1'b0;
    if (a == 3'd0 && d[3]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic enter();
    @(negedge clk);
    boot_enter = 1'b1;
    @(negedge clk);
    boot_enter = 1'b0;
    mdl_act = 1; mdl_ptr = 0; mdl_stage = '0;
    chk(boot_active == 1'b1, "R2 active after entry", 32'(boot_active), 1);
  endtask

  task automatic hw(logic [2:0] a, logic [7:0] d);
    bit was_act, pexp, sexp;
    was_act = mdl_act;
    pexp = exp_pass(mdl_act, a, d);
    sexp = 0;
    if (mdl_act) begin
      if (a == 3'd6) mdl_stage = d;
      else if (a == 3'd7) begin
        mdl_mem[mdl_ptr] = exp_word(mdl_stage, d);
        mdl_ptr++;
        if (mdl_ptr == WORDS) begin mdl_act = 0; sexp = 1; end
      end else if (a == 3'd0 && d[3]) begin
        mdl_act = 0; sexp = 1;
      end
    end
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
    chk(pass_wr == pexp, was_act ? "R8 pass strobe" : "R9 pass strobe", 32'(pass_wr), 32'(pexp));
    if (pexp)
      chk(pass_addr == a && pass_data == d, was_act ? "R8 pass fields" : "R9 pass fields",
          {21'd0, pass_addr, pass_data}, {21'd0, a, d});
    chk(core_start == sexp, "R7 start pulse", 32'(core_start), 32'(sexp));
    chk(boot_active == mdl_act, "R5 active level", 32'(boot_active), 32'(mdl_act));
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    pm_rd_addr = AW'(a);
    @(negedge clk);
    chk(pm_rd_data == mdl_mem[a], req, 32'(pm_rd_data), 32'(mdl_mem[a]));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(boot_active == 1'b0, "R1 reset active", 32'(boot_active), 0);
    chk(core_start == 1'b0, "R1 reset start", 32'(core_start), 0);
    chk(pass_wr == 1'b0, "R1 reset pass", 32'(pass_wr), 0);

    enter();
    hw(3'd7, 8'h5A);
    rd(0, "R4 staging cleared on entry");

    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 4)      hw(3'd6, 8'($urandom));
      else if (r < 8) hw(3'd7, 8'($urandom));
      else if (r < 9) hw(3'(1 + $urandom % 5), 8'($urandom));
      else            hw(3'd0, 8'($urandom) & 8'hF7);
    end
    hw(3'd7, 8'h11);
    hw(3'd7, 8'h22);

    hw(3'd0, 8'h08);
    chk(core_start_addr == '0, "R7 start address", 32'(core_start_addr), 0);
    @(negedge clk);
    chk(core_start == 1'b0, "R7 start single cycle", 32'(core_start), 0);
    chk(boot_active == 1'b0, "R6 early exit", 32'(boot_active), 0);
    for (int a = 0; a < mdl_ptr; a++) rd(a, "R3 R10 loaded word");
    chk(mdl_mem[mdl_ptr-1][15:8] == mdl_mem[mdl_ptr-2][15:8], "R4 staging reused",
        32'(mdl_mem[mdl_ptr-1]), 32'(mdl_mem[mdl_ptr-2]));

    hw(3'd6, 8'hEE);
    hw(3'd7, 8'hDD);
    hw(3'd0, 8'h08);
    for (int a = 0; a < 4; a++) rd(a, "R9 memory unchanged after exit");

    enter();
    hw(3'd6, 8'hAB);
    hw(3'd7, 8'hCD);
    rd(0, "R2 restart at word zero");
    chk(mdl_mem[0] == 16'hABCD, "R3 word order", 32'(mdl_mem[0]), 32'hABCD);

    while (mdl_act) begin
      if (mdl_ptr == WORDS - 1)
        chk(boot_active == 1'b1, "R5 still active before last word", 32'(boot_active), 1);
      if ($urandom % 4 != 0) hw(3'd6, 8'($urandom));
      hw(3'd7, 8'($urandom));
    end
    @(negedge clk);
    chk(core_start == 1'b0, "R7 start single cycle after full load", 32'(core_start), 0);
    rd(WORDS - 1, "R5 last word stored");
    rd(0, "R3 first word of full load");
    for (int i = 0; i < 64; i++) rd(int'($urandom % WORDS), "R10 random read");

    hw(3'd7, 8'h77);
    rd(0, "R9 no write after full load");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule